// File: doc/BRIEF.md
# Interrupt Pin Redirection Dispatcher

This block watches a bank of interrupt input pins and turns each one that fires into an interrupt message. A 64-bit redirection entry for each pin is supplied by a separate register window. The entry decides how the pin is read (edge or level, active high or active low) and what the message carries: vector, delivery mode, destination, destination mode, trigger kind and polarity. Messages leave through a valid/ready port. Whatever sits downstream decides which processor takes them.

A scan pointer visits the pins one per cycle in rising index order and wraps from the last pin to pin 0. When the pin under the pointer is eligible, its message is loaded into an output register, and the pointer stays on that pin until the message is taken. Level pins that have delivered a message are held off by a per-pin hold flag. An end-of-interrupt input carrying the same vector clears that flag. The block hands the hold flags and the per-pin waiting flags back to the register window so they can be read.

Top module: `irq_redir_dispatch`

## Requirements
- R1: After reset, `msg_valid`, `extint_err`, every bit of `entry_busy` and every bit of `level_hold` read 0.
- R2: The scan visits pins in rising index order and wraps from the last pin to pin 0. While a message is waiting, the pointer stays on that pin. When several pins are pending, their messages therefore come out in cyclically ascending pin order.
- R3: Each message copies fields from its pin's entry: vector from bits 7:0, delivery mode from bits 10:8, destination mode from bit 11, polarity from bit 13, trigger kind from bit 15 (1 = level), and destination from bits 63:56. `msg_pin` carries the pin index. Reserved delivery modes 011 and 110 are sent unchanged.
- R4: An entry with bit 16 (mask) set sends no message, but its pending state is kept. An edge event seen while masked is delivered once the mask is cleared.
- R5: On an edge pin, a rise of the asserted level sets pending. Each rise produces exactly one message, and pending clears when that message is accepted.
- R6: On a level pin, pending follows the asserted level. An accepted message sets `level_hold` for that pin, and no further message leaves that pin while the hold is set. An end-of-interrupt with a different vector has no effect. An end-of-interrupt with the pin's vector clears the hold, and the pin is delivered again if it is still asserted. A deasserted level pin sends nothing.
- R7: Polarity bit 13 set makes the pin active low, so it is asserted while its input is 0.
- R8: While `msg_valid` is high and `msg_ready` is low, every message output holds steady and no pending event is lost.
- R9: Delivery mode 111 (external-controller mode) is never sent. When such a pin becomes eligible, `extint_err` pulses high for one cycle, and the edge pending state is discarded.
- R10: `entry_busy[i]` is 1 exactly while a message from pin i waits on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_PINS | Raw interrupt pins |
| rte_flat | input | NUM_PINS*64 | Redirection entries, pin i at bits i*64 +: 64 |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being ended |
| msg_valid | output | 1 | Message waiting |
| msg_ready | input | 1 | Receiver takes the message |
| msg_vector | output | 8 | Message vector |
| msg_dlv | output | 3 | Delivery mode |
| msg_dest_mode | output | 1 | Destination mode |
| msg_dest | output | 8 | Destination |
| msg_level | output | 1 | Trigger kind, 1 = level |
| msg_active_low | output | 1 | Polarity |
| msg_pin | output | IDX_W | Source pin index |
| entry_busy | output | NUM_PINS | Per-pin message-waiting flags |
| level_hold | output | NUM_PINS | Per-pin level hold flags |
| extint_err | output | 1 | One-cycle pulse on an unsent mode-111 entry |

## Verification
The assertions assume that trigger kind and mask change only while the pin has no message waiting. They also assume `rte_flat` never switches a pin between edge and level in the same cycle that its pending state changes. The bench respects this by editing entries only while `msg_valid` is low and the affected pin is idle. Inputs and entries change at the falling edge. Edge pulses last two cycles, so a rise is always registered before the pin returns to idle.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam int RTE_W = 64;

  typedef enum logic [2:0] {
    DLV_FIXED  = 3'd0,
    DLV_LOWPRI = 3'd1,
    DLV_SMI    = 3'd2,
    DLV_RSV3   = 3'd3,
    DLV_NMI    = 3'd4,
    DLV_INIT   = 3'd5,
    DLV_RSV6   = 3'd6,
    DLV_EXTCTL = 3'd7
  } dlv_e;

  typedef struct packed {
    logic [7:0] dest;
    logic       masked;
    logic       level;
    logic       active_low;
    logic       dest_mode;
    logic [2:0] dlv;
    logic [7:0] vector;
  } rte_t;

  function automatic rte_t rte_unpack(input logic [RTE_W-1:0] w);
    rte_t r;
    r.vector     = w[7:0];
    r.dlv        = w[10:8];
    r.dest_mode  = w[11];
    r.active_low = w[13];
    r.level      = w[15];
    r.masked     = w[16];
    r.dest       = w[63:56];
    return r;
  endfunction

endpackage

// File: rtl/irq_pin_track.sv
module irq_pin_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw,
  input  logic       active_low,
  input  logic       level,
  input  logic [7:0] vector,
  input  logic       eoi_valid,
  input  logic [7:0] eoi_vector,
  input  logic       sent,
  input  logic       drop,
  output logic       pend,
  output logic       hold
);

  logic asserted, asserted_q, rise, eoi_hit;
  logic pend_q, pend_d, hold_q, hold_d;

  always_comb begin
    asserted = raw ^ active_low;
    rise     = asserted & ~asserted_q;
    eoi_hit  = eoi_valid & (eoi_vector == vector);
    if (level) pend_d = asserted;
    else       pend_d = (pend_q & ~(sent | drop)) | rise;
    hold_d = (hold_q & ~eoi_hit) | (sent & level);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asserted_q <= 1'b0;
      pend_q     <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      asserted_q <= asserted;
      pend_q     <= pend_d;
      hold_q     <= hold_d;
    end
  end

  assign pend = pend_q;
  assign hold = hold_q;

  // R6
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> $past(sent && level));

  // R5
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pend_q) && !level && $past(!level)) |-> $past(sent || drop));

endmodule

// File: rtl/irq_scan_ctrl.sv
module irq_scan_ctrl
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rte_t                ent [NUM_PINS],
  input  logic [NUM_PINS-1:0] pend,
  input  logic [NUM_PINS-1:0] hold,
  input  logic                msg_ready,
  output logic                msg_valid,
  output rte_t                msg_ent,
  output logic [IDX_W-1:0]    msg_pin,
  output logic [NUM_PINS-1:0] sent,
  output logic [NUM_PINS-1:0] drop,
  output logic                ext_err
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PINS - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d, pin_q;
  logic             vld_q, vld_d, err_q;
  rte_t             ent_q, cur;
  logic             elig, launch, ext_hit, accept, advance;

  always_comb begin
    cur     = ent[ptr_q];
    elig    = pend[ptr_q] & ~cur.masked & ~(cur.level & hold[ptr_q]);
    accept  = vld_q & msg_ready;
    launch  = ~vld_q & elig & (cur.dlv != DLV_EXTCTL);
    ext_hit = ~vld_q & elig & (cur.dlv == DLV_EXTCTL);
    advance = accept | (~vld_q & ~launch);
    ptr_d   = ptr_q;
    if (advance) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    vld_d   = launch | (vld_q & ~msg_ready);
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_onehot
    assign sent[i] = accept & (pin_q == IDX_W'(i));
    assign drop[i] = ext_hit & (ptr_q == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      vld_q <= vld_d;
      err_q <= ext_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
      pin_q <= '0;
    end else if (launch) begin
      ent_q <= cur;
      pin_q <= ptr_q;
    end
  end

  assign msg_valid = vld_q;
  assign msg_ent   = ent_q;
  assign msg_pin   = pin_q;
  assign ext_err   = err_q;

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !msg_ready) |=> (vld_q && $stable(ent_q) && $stable(pin_q)));

  // R9
  no_extctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (ent_q.dlv != DLV_EXTCTL));

  // R2
  pin_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (pin_q == ptr_q));

  // R4
  launch_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(pend[ptr_q] && !ent[ptr_q].masked));

  // R6
  hold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> !$past(ent[ptr_q].level && hold[ptr_q]));

endmodule

// File: rtl/irq_redir_dispatch.sv
module irq_redir_dispatch
  import irq_redir_pkg::*;
#(
  parameter  int NUM_PINS = 24,
  localparam int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PINS-1:0]       irq_in,
  input  logic [NUM_PINS*RTE_W-1:0] rte_flat,
  input  logic                      eoi_valid,
  input  logic [7:0]                eoi_vector,
  output logic                      msg_valid,
  input  logic                      msg_ready,
  output logic [7:0]                msg_vector,
  output logic [2:0]                msg_dlv,
  output logic                      msg_dest_mode,
  output logic [7:0]                msg_dest,
  output logic                      msg_level,
  output logic                      msg_active_low,
  output logic [IDX_W-1:0]          msg_pin,
  output logic [NUM_PINS-1:0]       entry_busy,
  output logic [NUM_PINS-1:0]       level_hold,
  output logic                      extint_err
);

  rte_t                ent [NUM_PINS];
  rte_t                msg_ent;
  logic [NUM_PINS-1:0] pend, hold, sent, drop;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [RTE_W-1:0] word;
    logic             rte_unused;
    assign word       = rte_flat[i*RTE_W +: RTE_W];
    assign ent[i]     = rte_unpack(word);
    assign rte_unused = ^{word[55:17], word[14], word[12]};

    irq_pin_track u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw       (irq_in[i]),
      .active_low(ent[i].active_low),
      .level     (ent[i].level),
      .vector    (ent[i].vector),
      .eoi_valid (eoi_valid),
      .eoi_vector(eoi_vector),
      .sent      (sent[i]),
      .drop      (drop[i]),
      .pend      (pend[i]),
      .hold      (hold[i])
    );

    assign entry_busy[i] = msg_valid & (msg_pin == IDX_W'(i));
  end

  irq_scan_ctrl #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .ent      (ent),
    .pend     (pend),
    .hold     (hold),
    .msg_ready(msg_ready),
    .msg_valid(msg_valid),
    .msg_ent  (msg_ent),
    .msg_pin  (msg_pin),
    .sent     (sent),
    .drop     (drop),
    .ext_err  (extint_err)
  );

  assign msg_vector     = msg_ent.vector;
  assign msg_dlv        = msg_ent.dlv;
  assign msg_dest_mode  = msg_ent.dest_mode;
  assign msg_dest       = msg_ent.dest;
  assign msg_level      = msg_ent.level;
  assign msg_active_low = msg_ent.active_low;
  assign level_hold     = hold;

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    extint_err |=> !extint_err);

endmodule

// File: tb/irq_redir_dispatch_bench.sv
`timescale 1ns/1ps
module irq_redir_dispatch_bench;

  localparam int N = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_in;
  logic [63:0]   ent [N];
  logic [N*64-1:0] rte_flat;
  logic          eoi_valid;
  logic [7:0]    eoi_vector;
  logic          msg_valid, msg_ready;
  logic [7:0]    msg_vector, msg_dest;
  logic [2:0]    msg_dlv;
  logic          msg_dest_mode, msg_level, msg_active_low;
  logic [4:0]    msg_pin;
  logic [N-1:0]  entry_busy, level_hold;
  logic          extint_err;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) rte_flat[i*64 +: 64] = ent[i];

  irq_redir_dispatch u_irq_redir_dispatch (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rte_flat(rte_flat),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dlv(msg_dlv), .msg_dest_mode(msg_dest_mode), .msg_dest(msg_dest),
    .msg_level(msg_level), .msg_active_low(msg_active_low), .msg_pin(msg_pin),
    .entry_busy(entry_busy), .level_hold(level_hold), .extint_err(extint_err)
  );

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dlv,
                                     input logic dm, input logic pol, input logic lvl,
                                     input logic msk, input logic [7:0] dest);
    return {dest, 39'b0, msk, lvl, 1'b0, pol, 1'b0, dm, dlv, vec};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_msg(output bit got);
    got = 1'b0;
    for (int k = 0; k < 100 && !got; k++) begin
      @(negedge clk);
      if (msg_valid) got = 1'b1;
    end
  endtask

  task automatic no_msg(input int n, output bit seen);
    seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
  endtask

  task automatic take();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic pulse(input int p);
    irq_in[p] = ~ent[p][13];
    tick(2);
    irq_in[p] = ent[p][13];
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_vector = v;
    eoi_valid  = 1'b1;
    @(negedge clk);
    eoi_valid  = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit got, seen;
    int p1, p2, desc;
    int pins [3];
    int errs;
    logic [N-1:0] hit;

    rst_n = 1'b0; msg_ready = 1'b0; eoi_valid = 1'b0; eoi_vector = '0;
    for (int i = 0; i < N; i++) begin
      ent[i] = mk(8'h20 + 8'(i), 3'(i % 7), 1'(i & 1), (i % 3) == 0, 1'b0, 1'b0,
                  8'(i * 5 + 1));
      irq_in[i] = ent[i][13];
    end
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1: reset state
    check(!msg_valid && !extint_err, "R1 idle outputs", {msg_valid, extint_err}, 0);
    check(entry_busy == '0 && level_hold == '0, "R1 flags", {entry_busy, level_hold}, 0);

    // R3 R5 R7 R10: sweep every pin, both polarities, all sendable modes
    for (int i = 0; i < N; i++) begin
      pulse(i);
      wait_msg(got);
      check(got && msg_pin == 5'(i), "R5 edge message pin", msg_pin, i);
      check(msg_vector == 8'h20 + 8'(i), "R3 vector", msg_vector, 8'h20 + i);
      check(msg_dlv == 3'(i % 7), "R3 delivery mode", msg_dlv, i % 7);
      check(msg_dest_mode == 1'(i & 1) && msg_dest == 8'(i * 5 + 1), "R3 destination",
            {msg_dest_mode, msg_dest}, {1'(i & 1), 8'(i * 5 + 1)});
      check(msg_level == 1'b0 && msg_active_low == ((i % 3) == 0), "R7 polarity field",
            msg_active_low, (i % 3) == 0);
      check(entry_busy == (N'(1) << i), "R10 busy while waiting", entry_busy, N'(1) << i);
      take();
      check(entry_busy == '0 && !msg_valid, "R10 busy cleared", entry_busy, 0);
    end
    no_msg(60, seen);
    check(!seen, "R5 one message per edge", seen, 0);

    // R6: level pin with hold and end-of-interrupt
    ent[5] = mk(8'h45, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h11);
    tick(1);
    irq_in[5] = 1'b1;
    wait_msg(got);
    check(got && msg_pin == 5'd5 && msg_level, "R6 level message", msg_pin, 5);
    take();
    check(level_hold == (N'(1) << 5), "R6 hold set", level_hold, N'(1) << 5);
    no_msg(60, seen);
    check(!seen, "R6 no redelivery under hold", seen, 0);
    eoi(8'h46);
    no_msg(60, seen);
    check(!seen && level_hold[5], "R6 mismatched EOI ignored", {seen, level_hold[5]}, 1);
    eoi(8'h45);
    check(!level_hold[5], "R6 matching EOI clears", level_hold[5], 0);
    wait_msg(got);
    check(got && msg_pin == 5'd5, "R6 redelivery when still asserted", msg_pin, 5);
    take();
    irq_in[5] = 1'b0;
    tick(2);
    eoi(8'h45);
    no_msg(60, seen);
    check(!seen && level_hold == '0, "R6 deasserted level silent", {seen, level_hold}, 0);

    // R7: active-low level pin
    ent[6] = mk(8'h26, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 8'h66);
    tick(1);
    irq_in[6] = 1'b0;
    wait_msg(got);
    check(got && msg_pin == 5'd6 && msg_active_low, "R7 active-low level", msg_pin, 6);
    take();
    irq_in[6] = 1'b1;
    tick(2);
    eoi(8'h26);
    no_msg(40, seen);
    check(!seen, "R7 high input idle when active low", seen, 0);

    // R4: mask keeps pending
    ent[9][16] = 1'b1;
    pulse(9);
    no_msg(60, seen);
    check(!seen, "R4 masked entry silent", seen, 0);
    ent[9][16] = 1'b0;
    wait_msg(got);
    check(got && msg_pin == 5'd9, "R4 pending kept through mask", msg_pin, 9);
    take();

    // R8: back-pressure
    irq_in[12] = ~ent[12][13];
    irq_in[13] = ~ent[13][13];
    tick(2);
    irq_in[12] = ent[12][13];
    irq_in[13] = ent[13][13];
    wait_msg(got);
    p1 = int'(msg_pin);
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      tick(1);
      if (!msg_valid || int'(msg_pin) != p1 || msg_vector != 8'h20 + 8'(p1)) seen = 1'b1;
    end
    check(got && !seen, "R8 output held while not ready", seen, 0);
    take();
    wait_msg(got);
    p2 = int'(msg_pin);
    check(got && p1 != p2 && (p1 == 12 || p1 == 13) && (p2 == 12 || p2 == 13),
          "R8 nothing dropped", p2, 25 - p1);
    take();

    // R2: ordering among three pending pins
    hit = '0;
    irq_in[20] = ~ent[20][13]; irq_in[3] = ~ent[3][13]; irq_in[7] = ~ent[7][13];
    tick(2);
    irq_in[20] = ent[20][13]; irq_in[3] = ent[3][13]; irq_in[7] = ent[7][13];
    for (int k = 0; k < 3; k++) begin
      wait_msg(got);
      pins[k] = got ? int'(msg_pin) : 0;
      if (got) hit[msg_pin] = 1'b1;
      take();
    end
    desc = 0;
    for (int k = 0; k < 3; k++) if (pins[(k + 1) % 3] < pins[k]) desc++;
    check(hit == ((N'(1) << 3) | (N'(1) << 7) | (N'(1) << 20)), "R2 all delivered",
          hit, (N'(1) << 3) | (N'(1) << 7) | (N'(1) << 20));
    check(desc == 1, "R2 cyclic ascending order", desc, 1);

    // R9: mode 111 not sent
    ent[11][10:8] = 3'd7;
    tick(1);
    irq_in[11] = ~ent[11][13];
    errs = 0; seen = 1'b0;
    for (int k = 0; k < 60; k++) begin
      tick(1);
      if (k == 1) irq_in[11] = ent[11][13];
      if (extint_err) errs++;
      if (msg_valid) seen = 1'b1;
    end
    check(errs == 1 && !seen, "R9 error pulse, no message", errs, 1);
    ent[11][10:8] = 3'd0;
    no_msg(60, seen);
    check(!seen, "R9 edge pending discarded", seen, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule